// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flags

This block compares two IEEE-754 scalars and turns the outcome into a four-bit condition flag nibble. The nibble holds N, Z, C and V. Both operands use the same precision: either double precision, on the full 64-bit inputs, or single precision, on the low 32 bits. The second operand can be replaced by positive zero. A signaling select chooses which NaN inputs raise the invalid-operation output.

In conditional mode the block first tests a four-bit condition code against the flag nibble currently in force. If the condition holds, the compare runs as usual. If it fails, no compare takes place: the output flags are loaded from an immediate nibble and invalid stays low.

Inputs are sampled on every rising clock edge. The result appears on registered outputs one cycle later.

Top module: `fpFlagCompare`

## Requirements
- R1: When either operand is a NaN (and the compare runs), the flags become N=0, Z=0, C=1, V=1. The output nibble is ordered N at bit 3, Z at bit 2, C at bit 1 and V at bit 0, so this pattern is 4'b0011.
- R2: For ordered operands V is 0, C is 1 when a >= b, Z is 1 when a == b, and N is 1 when a < b. Infinities are ordered as the largest magnitudes.
- R3: Zeros of opposite sign compare equal, giving flags 4'b0110.
- R4: With `zeroCmp` high, the value on `opB` is ignored and the second operand is +0.0 of the selected precision.
- R5: With `dblSel` high both operands are 64-bit doubles. With it low both are singles taken from bits [31:0], and bits [63:32] have no effect.
- R6: With `condMode` high and the condition false, the flags take `immFlags` and `invalidOut` is 0. Immediate bit 3 goes to N, bit 2 to Z, bit 1 to C and bit 0 to V.
- R7: With `condMode` high and the condition true, the normal compare result is produced. With `condMode` low the compare always runs.
- R8: Bits [3:1] of `condCode` select the base test and bit 0 inverts it, using `flagsIn` ordered N,Z,C,V from bit 3 down. The base tests are: 000 Z; 001 C; 010 N; 011 V; 100 C and not Z; 101 N equals V; 110 not Z and N equals V; 111 always true. Codes 4'b1110 and 4'b1111 are both always true.
- R9: With `sigMode` high, `invalidOut` is 1 for any NaN operand. With it low, `invalidOut` is 1 only when an operand is a signaling NaN, meaning a NaN whose top mantissa bit is 0.
- R10: Outputs are registered with one cycle of latency. Active-low `rstN` clears `flagsOut` and `invalidOut` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 64 | First operand (low 32 bits in single mode) |
| opB | input | 64 | Second operand (low 32 bits in single mode) |
| dblSel | input | 1 | 1 = double precision, 0 = single precision |
| zeroCmp | input | 1 | Replace second operand with +0.0 |
| sigMode | input | 1 | 1 = any NaN is invalid, 0 = only signaling NaN |
| condMode | input | 1 | Enable conditional compare |
| condCode | input | 4 | Condition code tested on flagsIn |
| flagsIn | input | 4 | Current flag nibble N,Z,C,V |
| immFlags | input | 4 | Flags loaded when the condition fails |
| flagsOut | output | 4 | Resulting flag nibble N,Z,C,V |
| invalidOut | output | 1 | Invalid-operation indication |

## Verification
The hardest situation to reach from the ports is one where the block must tell NaN kinds apart, or tell ordered values apart, while the operands share their exponent. Examples are a signaling NaN against a quiet NaN under quiet mode, and two values of equal magnitude but opposite sign. Uniformly random 64-bit words almost never produce these cases. The stimulus therefore draws each operand from a weighted menu: signed zeros, infinities, quiet and signaling NaNs, a copy of the other operand, and random words. Single-precision cases get random upper bits. The random runs are backed by directed cases that walk all sixteen condition codes over chosen flag nibbles.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int FP_MAX_W = 64;

  typedef struct packed {
    logic useImm;   // condition failed: take immediate flags
    logic sigAll;   // every NaN raises invalid
    logic useZero;  // second operand forced to +0
    logic dbl;      // double precision select
  } fcmpStrobe_t;

  typedef struct packed {
    logic                  isNan;
    logic                  isSnan;
    logic                  isZero;
    logic                  sign;
    logic [FP_MAX_W-2:0]   mag;
  } fpClass_t;
endpackage

// File: rtl/fcmpClassify.sv
module fcmpClassify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fpClass_t             cls
);
  localparam int MAG_W = EXP_W + MAN_W;

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;

  assign expField = val[MAG_W-1:MAN_W];
  assign manField = val[MAN_W-1:0];

  always_comb begin
    cls        = '0;
    cls.sign   = val[MAG_W];
    cls.isNan  = (&expField) && (|manField);
    cls.isSnan = cls.isNan && !manField[MAN_W-1];
    cls.isZero = (val[MAG_W-1:0] == '0);
    cls.mag    = {{(FP_MAX_W-1-MAG_W){1'b0}}, val[MAG_W-1:0]};
  end
endmodule

// File: rtl/fcmpCtrl.sv
module fcmpCtrl
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dblSel,
  input  logic        zeroCmp,
  input  logic        sigMode,
  input  logic        condMode,
  input  logic [3:0]  condCode,
  input  logic [3:0]  flagsIn,
  output fcmpStrobe_t strobe
);
  logic fN, fZ, fC, fV;
  logic baseTest, condTrue;

  assign {fN, fZ, fC, fV} = flagsIn;

  always_comb begin
    unique case (condCode[3:1])
      3'b000:  baseTest = fZ;
      3'b001:  baseTest = fC;
      3'b010:  baseTest = fN;
      3'b011:  baseTest = fV;
      3'b100:  baseTest = fC && !fZ;
      3'b101:  baseTest = (fN == fV);
      3'b110:  baseTest = !fZ && (fN == fV);
      default: baseTest = 1'b1;
    endcase
    if (condCode[3:1] == 3'b111) condTrue = 1'b1;
    else                         condTrue = baseTest ^ condCode[0];
  end

  assign strobe.useImm  = condMode && !condTrue;
  assign strobe.sigAll  = sigMode;
  assign strobe.useZero = zeroCmp;
  assign strobe.dbl     = dblSel;

  // R8: the always-true codes never fail
  p_always_true_r8: assert property (@(posedge clk) disable iff (!rstN)
    (condCode[3:1] == 3'b111) |-> !strobe.useImm);

  // R7: without conditional mode the compare always runs
  p_plain_compare_r7: assert property (@(posedge clk) disable iff (!rstN)
    !condMode |-> !strobe.useImm);
endmodule

// File: rtl/fcmpDatapath.sv
module fcmpDatapath
  import fcmp_pkg::*;
#(
  parameter int DBL_EXP = 11,
  parameter int DBL_MAN = 52,
  parameter int SGL_EXP = 8,
  parameter int SGL_MAN = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fcmpStrobe_t             strobe,
  input  logic [DBL_EXP+DBL_MAN:0] opA,
  input  logic [DBL_EXP+DBL_MAN:0] opB,
  input  logic [3:0]              immFlags,
  output logic [3:0]              flagsOut,
  output logic                    invalidOut
);
  localparam int DW = DBL_EXP + DBL_MAN + 1;
  localparam int SW = SGL_EXP + SGL_MAN + 1;

  logic [DW-1:0] opnd [2];
  fpClass_t      dblCls [2];
  fpClass_t      sglCls [2];
  fpClass_t      sel    [2];

  assign opnd[0] = opA;
  assign opnd[1] = strobe.useZero ? '0 : opB;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    fcmpClassify #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) u_dbl (
      .val (opnd[i]),
      .cls (dblCls[i])
    );
    fcmpClassify #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_sgl (
      .val (opnd[i][SW-1:0]),
      .cls (sglCls[i])
    );
    assign sel[i] = strobe.dbl ? dblCls[i] : sglCls[i];
  end

  logic unord, bothZero, isEq, isLt, badOp;
  logic [3:0] cmpFlags, nextFlags;
  logic nextInvalid;

  always_comb begin
    unord    = sel[0].isNan || sel[1].isNan;
    bothZero = sel[0].isZero && sel[1].isZero;
    isEq     = bothZero || (sel[0].sign == sel[1].sign && sel[0].mag == sel[1].mag);
    if (bothZero)
      isLt = 1'b0;
    else if (sel[0].sign != sel[1].sign)
      isLt = sel[0].sign;
    else if (sel[0].sign)
      isLt = sel[0].mag > sel[1].mag;
    else
      isLt = sel[0].mag < sel[1].mag;
    badOp    = strobe.sigAll ? unord : (sel[0].isSnan || sel[1].isSnan);
    cmpFlags = unord ? 4'b0011 : {isLt, isEq, !isLt, 1'b0};
    if (strobe.useImm) begin
      nextFlags   = immFlags;
      nextInvalid = 1'b0;
    end else begin
      nextFlags   = cmpFlags;
      nextInvalid = badOp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsOut   <= '0;
      invalidOut <= 1'b0;
    end else begin
      flagsOut   <= nextFlags;
      invalidOut <= nextInvalid;
    end
  end

  // R1: unordered compare gives the fixed pattern
  p_unordered_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.useImm && unord) |=> (flagsOut == 4'b0011));

  // R2: ordered compare clears V and never sets N together with C
  p_ordered_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.useImm && !unord) |=> (!flagsOut[0] && (flagsOut[3] != flagsOut[1])));

  // R6: failed condition loads the immediate and keeps invalid low
  p_imm_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.useImm |=> (flagsOut == $past(immFlags) && !invalidOut));

  // R9: signaling mode flags every NaN
  p_sig_invalid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.useImm && strobe.sigAll && unord) |=> invalidOut);

  // R2: equality implies C
  p_eq_has_c_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flagsOut[2] && !flagsOut[0] && !$past(strobe.useImm)) |-> flagsOut[1]);
endmodule

// File: rtl/fpFlagCompare.sv
module fpFlagCompare
  import fcmp_pkg::*;
#(
  parameter int DBL_EXP = 11,
  parameter int DBL_MAN = 52,
  parameter int SGL_EXP = 8,
  parameter int SGL_MAN = 23
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DBL_EXP+DBL_MAN:0] opA,
  input  logic [DBL_EXP+DBL_MAN:0] opB,
  input  logic                     dblSel,
  input  logic                     zeroCmp,
  input  logic                     sigMode,
  input  logic                     condMode,
  input  logic [3:0]               condCode,
  input  logic [3:0]               flagsIn,
  input  logic [3:0]               immFlags,
  output logic [3:0]               flagsOut,
  output logic                     invalidOut
);
  fcmpStrobe_t strobe;

  fcmpCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dblSel   (dblSel),
    .zeroCmp  (zeroCmp),
    .sigMode  (sigMode),
    .condMode (condMode),
    .condCode (condCode),
    .flagsIn  (flagsIn),
    .strobe   (strobe)
  );

  fcmpDatapath #(
    .DBL_EXP (DBL_EXP),
    .DBL_MAN (DBL_MAN),
    .SGL_EXP (SGL_EXP),
    .SGL_MAN (SGL_MAN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .immFlags   (immFlags),
    .flagsOut   (flagsOut),
    .invalidOut (invalidOut)
  );
endmodule

// File: tb/test_fpFlagCompare.sv
module test_fpFlagCompare;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        dblSel = 1'b0, zeroCmp = 1'b0, sigMode = 1'b0, condMode = 1'b0;
  logic [3:0]  condCode = '0, flagsIn = '0, immFlags = '0;
  logic [3:0]  flagsOut;
  logic        invalidOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpFlagCompare i_fpFlagCompare (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .dblSel(dblSel),
    .zeroCmp(zeroCmp), .sigMode(sigMode), .condMode(condMode),
    .condCode(condCode), .flagsIn(flagsIn), .immFlags(immFlags),
    .flagsOut(flagsOut), .invalidOut(invalidOut)
  );

  // R8 reference condition table
  function automatic bit refCond(input logic [3:0] cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !(c && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  // returns {invalid, N, Z, C, V}
  function automatic logic [4:0] refModel();
    int ew, mw;
    logic [63:0] a, b, mag [2];
    bit sgn [2], nan [2], snan [2];
    longint key [2];
    if (condMode && !refCond(condCode, flagsIn)) return {1'b0, immFlags};
    ew = dblSel ? 11 : 8;
    mw = dblSel ? 52 : 23;
    a = dblSel ? opA : {32'h0, opA[31:0]};
    b = zeroCmp ? 64'h0 : (dblSel ? opB : {32'h0, opB[31:0]});
    for (int k = 0; k < 2; k++) begin
      logic [63:0] w = (k == 0) ? a : b;
      logic [63:0] e = (w >> mw) & ((64'h1 << ew) - 1);
      logic [63:0] m = w & ((64'h1 << mw) - 1);
      sgn[k]  = w[ew + mw];
      mag[k]  = w & ((64'h1 << (ew + mw)) - 1);
      nan[k]  = (e == ((64'h1 << ew) - 1)) && (m != 0);
      snan[k] = nan[k] && !m[mw-1];
      key[k]  = sgn[k] ? -longint'(mag[k]) : longint'(mag[k]);
    end
    if (nan[0] || nan[1])
      return {(sigMode ? 1'b1 : (snan[0] || snan[1])), 4'b0011};
    return {1'b0, key[0] < key[1], key[0] == key[1], key[0] >= key[1], 1'b0};
  endfunction

  task automatic checkOut(input string tag);
    logic [4:0] exp;
    exp = refModel();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({invalidOut, flagsOut} !== exp) begin
      failures++;
      $display("FAIL %s: got inv=%b flags=%b expected inv=%b flags=%b",
               tag, invalidOut, flagsOut, exp[4], exp[3:0]);
    end
  endtask

  task automatic setPlain(input logic [63:0] a, input logic [63:0] b,
                          input bit d, input bit z, input bit s);
    opA = a; opB = b; dblSel = d; zeroCmp = z; sigMode = s;
    condMode = 0; condCode = 0; flagsIn = 0; immFlags = 0;
  endtask

  function automatic logic [63:0] pickOp(input bit d, input logic [63:0] other);
    logic [63:0] r = {$urandom, $urandom};
    int sel = $urandom_range(0, 9);
    logic [31:0] up = $urandom;
    if (d) begin
      case (sel)
        0: r = 64'h0;
        1: r = 64'h8000_0000_0000_0000;
        2: r = {$urandom_range(0, 1) == 1, 63'h7FF0_0000_0000_0000};
        3: r = 64'h7FF8_0000_0000_0001;
        4: r = 64'h7FF0_0000_0000_0005;
        5: r = other;
        6: r = other ^ 64'h8000_0000_0000_0000;
        default: ;
      endcase
    end else begin
      case (sel)
        0: r = {up, 32'h0};
        1: r = {up, 32'h8000_0000};
        2: r = {up, $urandom_range(0, 1) == 1, 31'h7F80_0000};
        3: r = {up, 32'h7FC0_0001};
        4: r = {up, 32'hFF80_0003};
        5: r = {up, other[31:0]};
        6: r = {up, other[31:0] ^ 32'h8000_0000};
        default: ;
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (flagsOut !== 4'b0 || invalidOut !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset: got %b/%b expected 0000/0", flagsOut, invalidOut);
    end
    rstN = 1'b1;

    // R2 ordered doubles: 1.0 vs 2.0, 2.0 vs 1.0, -1.0 vs 1.0
    setPlain(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 0, 0); checkOut("R2 lt");
    setPlain(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, 0); checkOut("R2 gt");
    setPlain(64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, 0); checkOut("R2 neg");
    setPlain(64'hFFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1, 0, 0); checkOut("R2 -inf");
    // R3 signed zeros
    setPlain(64'h8000_0000_0000_0000, 64'h0, 1, 0, 0); checkOut("R3 zeros dbl");
    setPlain(64'h0, {32'h0, 32'h8000_0000}, 0, 0, 0); checkOut("R3 zeros sgl");
    // R1 / R9 NaN handling
    setPlain(64'h7FF8_0000_0000_0000, 64'h0, 1, 0, 0); checkOut("R1 qnan quiet");
    setPlain(64'h7FF8_0000_0000_0000, 64'h0, 1, 0, 1); checkOut("R9 qnan signaling");
    setPlain(64'h0, 64'h7FF0_0000_0000_0001, 1, 0, 0); checkOut("R9 snan quiet");
    setPlain(64'h0, {32'h0, 32'h7F80_0001}, 0, 0, 0); checkOut("R9 snan single");
    // R4 zero compare ignores opB
    setPlain(64'h8000_0000_0000_0001, 64'h7FF0_0000_0000_0001, 1, 1, 1); checkOut("R4 zeroCmp dbl");
    setPlain({32'hDEAD_BEEF, 32'h3F80_0000}, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1); checkOut("R4 zeroCmp sgl");
    // R5 upper bits ignored in single mode
    setPlain({32'h7FF8_0000, 32'h3F80_0000}, {32'h1234_5678, 32'h3F80_0000}, 0, 0, 1); checkOut("R5 upper ignored");

    // R6/R7/R8 every condition code on several flag nibbles
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f += 5) begin
        setPlain(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, 0);
        condMode = 1; condCode = cc[3:0]; flagsIn = f[3:0]; immFlags = 4'(15 - f);
        checkOut("R8 condition");
      end
    end
    // R6 failed condition with NaN input keeps invalid low
    setPlain(64'h7FF0_0000_0000_0001, 64'h0, 1, 0, 1);
    condMode = 1; condCode = 4'd0; flagsIn = 4'b0000; immFlags = 4'b1010;
    checkOut("R6 imm over nan");
    // R7 true condition performs compare
    condCode = 4'd1; checkOut("R7 true cond");

    // random mix covering R1-related cases
    for (int it = 0; it < 4000; it++) begin
      logic [63:0] b;
      dblSel = $urandom_range(0, 1) == 1;
      b = {$urandom, $urandom};
      opB = b;
      opA = pickOp(dblSel, b);
      if ($urandom_range(0, 2) == 0) opB = pickOp(dblSel, opA);
      zeroCmp  = $urandom_range(0, 5) == 0;
      sigMode  = $urandom_range(0, 1) == 1;
      condMode = $urandom_range(0, 2) == 0;
      condCode = $urandom;
      flagsIn  = $urandom;
      immFlags = $urandom;
      checkOut("R1 R2 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule